// File: doc/BRIEF.md
# Two-Stage Converter Frame Sequencer

This block runs the digital timing of a two-stage converter from one master clock. A coarse successive-approximation stage comes first and a free-running oscillator integrator comes second. Every frame lasts thirteen master cycles and has three phases. The input is sampled for three cycles. A five-bit coarse search then takes one cycle per bit. Fine integration fills the last five cycles. All phase enables come from a single frame counter, so no edge of one phase can slip against another.

During the coarse phase the block takes one comparator decision per cycle, most significant bit first. The first decision is the sign of the sampled input. After each decision it switches a capacitor on one side of the differential array only, and that decision picks the side. The four upper capacitors move to the low rail. The least significant capacitor moves only to the mid-level reference, which leaves a residue centred on zero for the oscillator stage. Outside the integration phase, the oscillator is held on a fixed bias and is never reset. The finished code is published at frame end and then held for a whole frame.

Top module: `sar_phase_seq`

## Requirements
- R1: While `rstN` is high, frames repeat every 13 cycles. Each frame has `sampleEn` high for cycles 0-2, `coarseEn` high for cycles 3-7 and `fineEn` high for cycles 8-12, and exactly one of the three is high in every cycle.
- R2: If `rstN` is low at a rising edge, the next cycle is frame cycle 0 (sampling). In that cycle every capacitor select is low, `coarseCode` is 0 and `frameDone` is low.
- R3: `sampleStrobe` is high for exactly one cycle per frame, the last sampling cycle (cycle 2).
- R4: In coarse cycle k (frame cycle 3+k, k=0..4), `cmpHigh` becomes code bit 4-k. Bit 4 is the input sign, with 1 meaning positive.
- R5: After the decision for bit i (i=4..1), exactly one of `capRailP[i]` / `capRailN[i]` goes high from the next cycle: the P side when the decision was 1, the N side when it was 0. It stays high until the frame ends.
- R6: The bit-0 decision sets `capMidP` (decision 1) or `capMidN` (decision 0) and leaves every rail select unchanged.
- R7: Every capacitor select is low throughout the sampling phase.
- R8: `frameDone` is high for exactly one cycle per frame, the last integration cycle (cycle 12).
- R9: `coarseCode` changes only at the edge that ends a `frameDone` cycle. It then takes that frame's five decisions. `cmpHigh` outside the coarse phase has no effect on it.
- R10: `oscBias` is high during sampling and coarse cycles and low during integration cycles. No output resets the oscillator or its counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | master clock |
| rstN | input | 1 | synchronous reset, active low |
| cmpHigh | input | 1 | comparator decision, 1 = positive side higher |
| sampleEn | output | 1 | input sampling phase enable |
| coarseEn | output | 1 | coarse search phase enable |
| fineEn | output | 1 | fine integration phase enable |
| sampleStrobe | output | 1 | last sampling cycle, opens the sampling switch |
| oscBias | output | 1 | oscillator held on fixed bias |
| capRailP | output | 4 | positive-side capacitor to low rail, bits 4..1 |
| capRailN | output | 4 | negative-side capacitor to low rail, bits 4..1 |
| capMidP | output | 1 | positive-side LSB capacitor to mid-level reference |
| capMidN | output | 1 | negative-side LSB capacitor to mid-level reference |
| coarseCode | output | 5 | published coarse code |
| frameDone | output | 1 | one-cycle end-of-frame pulse |

## Verification
The bench drives all-zero, all-one, alternating and single-bit decision patterns, with the comparator driven to the opposite level outside the coarse window. A design that sampled the comparator one cycle off, or outside that window, would publish a shifted or corrupted code. The bench checks the array state at the end of the frame, which would expose a design that switched both sides, used the wrong side, or drove the last bit to a rail. A reset in the middle of the search must clear the array and the code at once and restart at sampling. The bench also checks that the published code never changes in the middle of a frame, and it counts the oscillator's gated cycles to confirm the bias duty.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;
  localparam int unsigned SAR_BITS     = 5;
  localparam int unsigned DEF_SAMPLE   = 3;
  localparam int unsigned DEF_INTEG    = 5;

  typedef enum logic [1:0] {
    PH_SAMPLE = 2'd0,
    PH_COARSE = 2'd1,
    PH_FINE   = 2'd2
  } phase_e;

  typedef struct packed {
    logic                clearArray;
    logic                bitStrobe;
    logic [SAR_BITS-1:0] bitSel;
    logic                publish;
  } seqStrobe_t;
endpackage

// File: rtl/sar_seq_ctrl.sv
module sar_seq_ctrl
  import sar_seq_pkg::*;
#(
  parameter int unsigned SampleCycles = DEF_SAMPLE,
  parameter int unsigned IntegCycles  = DEF_INTEG
) (
  input  logic       clk,
  input  logic       rstN,
  output phase_e     phase,
  output logic       sampleStrobe,
  output logic       frameDone,
  output seqStrobe_t strobes
);
  localparam int unsigned FrameCycles = SampleCycles + SAR_BITS + IntegCycles;
  localparam int unsigned CntW        = $clog2(FrameCycles);
  localparam logic [CntW-1:0] SampleLast = CntW'(SampleCycles - 1);
  localparam logic [CntW-1:0] CoarseFirst = CntW'(SampleCycles);
  localparam logic [CntW-1:0] FineFirst  = CntW'(SampleCycles + SAR_BITS);
  localparam logic [CntW-1:0] LastCycle  = CntW'(FrameCycles - 1);

  logic [CntW-1:0]     frameCnt;
  logic                atLast;
  logic [SAR_BITS-1:0] bitHit;

  assign atLast = (frameCnt == LastCycle);

  // single frame counter: every phase is a decode of it
  always_ff @(posedge clk) begin
    if (!rstN)       frameCnt <= '0;
    else if (atLast) frameCnt <= '0;
    else             frameCnt <= frameCnt + 1'b1;
  end

  always_comb begin
    if (frameCnt < CoarseFirst)    phase = PH_SAMPLE;
    else if (frameCnt < FineFirst) phase = PH_COARSE;
    else                           phase = PH_FINE;
  end

  // bit b is resolved in coarse cycle (SAR_BITS-1-b): MSB first
  for (genvar b = 0; b < SAR_BITS; b++) begin : g_bitDecode
    localparam logic [CntW-1:0] HitCycle = CntW'(SampleCycles + SAR_BITS - 1 - b);
    assign bitHit[b] = (frameCnt == HitCycle);
  end

  assign sampleStrobe       = (frameCnt == SampleLast);
  assign frameDone          = atLast;
  assign strobes.clearArray = atLast;
  assign strobes.publish    = atLast;
  assign strobes.bitStrobe  = (phase == PH_COARSE);
  assign strobes.bitSel     = bitHit;

  AST_FRAME_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    frameDone |=> (phase == PH_SAMPLE && !frameDone && !sampleStrobe)); // R8
  AST_STROBE_TO_COARSE: assert property (@(posedge clk) disable iff (!rstN)
    sampleStrobe |=> (phase == PH_COARSE)); // R3
  AST_COARSE_TO_FINE: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.bitStrobe && strobes.bitSel[0]) |=> (phase == PH_FINE)); // R1
  AST_ONE_BIT_SEL: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strobes.bitSel)); // R4
endmodule

// File: rtl/sar_seq_datapath.sv
module sar_seq_datapath
  import sar_seq_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  seqStrobe_t          strobes,
  input  logic                cmpHigh,
  output logic [SAR_BITS-1:0] coarseCode,
  output logic [SAR_BITS-1:1] capRailP,
  output logic [SAR_BITS-1:1] capRailN,
  output logic                capMidP,
  output logic                capMidN
);
  logic [SAR_BITS-1:0] workCode;
  logic                takeBit;

  assign takeBit = strobes.bitStrobe;

  // decisions accumulate here; nothing reaches coarseCode until publish
  always_ff @(posedge clk) begin
    if (!rstN || strobes.clearArray) begin
      workCode <= '0;
    end else if (takeBit) begin
      for (int b = 0; b < SAR_BITS; b++)
        if (strobes.bitSel[b]) workCode[b] <= cmpHigh;
    end
  end

  // one-sided switching: the decision picks which half of the array moves
  always_ff @(posedge clk) begin
    if (!rstN || strobes.clearArray) begin
      capRailP <= '0;
      capRailN <= '0;
      capMidP  <= 1'b0;
      capMidN  <= 1'b0;
    end else if (takeBit) begin
      for (int b = 1; b < SAR_BITS; b++) begin
        if (strobes.bitSel[b]) begin
          if (cmpHigh) capRailP[b] <= 1'b1;
          else         capRailN[b] <= 1'b1;
        end
      end
      // last step only reaches the mid-level reference: zero-mean residue
      if (strobes.bitSel[0]) begin
        if (cmpHigh) capMidP <= 1'b1;
        else         capMidN <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                coarseCode <= '0;
    else if (strobes.publish) coarseCode <= workCode;
  end

  AST_ONE_SIDE: assert property (@(posedge clk) disable iff (!rstN)
    takeBit |=> ($countones({capRailP, capRailN, capMidP, capMidN})
                 == $countones($past({capRailP, capRailN, capMidP, capMidN})) + 1)); // R5
  AST_MID_LAST: assert property (@(posedge clk) disable iff (!rstN)
    (takeBit && strobes.bitSel[0]) |=>
      ($stable(capRailP) && $stable(capRailN) && (capMidP == $past(cmpHigh)) && (capMidP != capMidN))); // R6
  AST_CODE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.publish |=> $stable(coarseCode)); // R9
endmodule

// File: rtl/sar_phase_seq.sv
module sar_phase_seq
  import sar_seq_pkg::*;
#(
  parameter int unsigned SampleCycles = DEF_SAMPLE,
  parameter int unsigned IntegCycles  = DEF_INTEG
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                cmpHigh,
  output logic                sampleEn,
  output logic                coarseEn,
  output logic                fineEn,
  output logic                sampleStrobe,
  output logic                oscBias,
  output logic [SAR_BITS-1:1] capRailP,
  output logic [SAR_BITS-1:1] capRailN,
  output logic                capMidP,
  output logic                capMidN,
  output logic [SAR_BITS-1:0] coarseCode,
  output logic                frameDone
);
  phase_e     phase;
  seqStrobe_t strobes;

  sar_seq_ctrl #(
    .SampleCycles(SampleCycles),
    .IntegCycles (IntegCycles)
  ) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .phase       (phase),
    .sampleStrobe(sampleStrobe),
    .frameDone   (frameDone),
    .strobes     (strobes)
  );

  sar_seq_datapath u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .cmpHigh   (cmpHigh),
    .coarseCode(coarseCode),
    .capRailP  (capRailP),
    .capRailN  (capRailN),
    .capMidP   (capMidP),
    .capMidN   (capMidN)
  );

  assign sampleEn = (phase == PH_SAMPLE);
  assign coarseEn = (phase == PH_COARSE);
  assign fineEn   = (phase == PH_FINE);
  // oscillator keeps running on a fixed bias outside integration
  assign oscBias  = !fineEn;

  AST_PHASE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    $onehot({sampleEn, coarseEn, fineEn})); // R1
  AST_CLEAR_IN_SAMPLE: assert property (@(posedge clk) disable iff (!rstN)
    sampleEn |-> (capRailP == '0 && capRailN == '0 && !capMidP && !capMidN)); // R7
endmodule

// File: tb/sar_phase_seq_bench.sv
`timescale 1ns/1ps
module sar_phase_seq_bench;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cmpHigh = 1'b0;
  logic       sampleEn, coarseEn, fineEn, sampleStrobe, oscBias;
  logic [4:1] capRailP, capRailN;
  logic       capMidP, capMidN, frameDone;
  logic [4:0] coarseCode;

  int nChecks = 0;
  int nErr = 0;
  int oscCount = 0;

  always #4 clk = ~clk;

  sar_phase_seq u_sar_phase_seq (
    .clk(clk), .rstN(rstN), .cmpHigh(cmpHigh),
    .sampleEn(sampleEn), .coarseEn(coarseEn), .fineEn(fineEn),
    .sampleStrobe(sampleStrobe), .oscBias(oscBias),
    .capRailP(capRailP), .capRailN(capRailN),
    .capMidP(capMidP), .capMidN(capMidN),
    .coarseCode(coarseCode), .frameDone(frameDone)
  );

  // gated count source standing in for the oscillator; it is never cleared
  always @(posedge clk) if (rstN) oscCount <= oscCount + (oscBias ? 1 : 3);

  // {noise, pattern}: noise drives cmpHigh outside the coarse window
  localparam logic [5:0] VEC [0:5] = '{
    6'b0_10110, 6'b1_00000, 6'b0_11111, 6'b1_10000, 6'b0_01111, 6'b1_01010
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nErr++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic runFrame(input logic [4:0] pat, input logic noise, input logic [4:0] prevCode);
    for (int c = 0; c < 13; c++) begin
      chk({sampleEn, coarseEn, fineEn} == {c < 3, c >= 3 && c < 8, c >= 8}, "R1 phase",
          {sampleEn, coarseEn, fineEn}, {c < 3, c >= 3 && c < 8, c >= 8});
      chk(sampleStrobe == (c == 2), "R3 sampleStrobe", sampleStrobe, c == 2);
      chk(frameDone == (c == 12), "R8 frameDone", frameDone, c == 12);
      chk(oscBias == (c < 8), "R10 oscBias", oscBias, c < 8);
      chk(coarseCode == prevCode, "R9 code held", coarseCode, prevCode);
      if (c < 3)
        chk({capRailP, capRailN, capMidP, capMidN} == 10'd0, "R7 array clear",
            {capRailP, capRailN, capMidP, capMidN}, 0);
      if (c == 12) begin
        chk(capRailP == pat[4:1], "R5 rail P side", capRailP, pat[4:1]);
        chk(capRailN == ~pat[4:1], "R5 rail N side", capRailN, ~pat[4:1]);
        chk({capMidP, capMidN} == {pat[0], ~pat[0]}, "R6 mid-level LSB",
            {capMidP, capMidN}, {pat[0], ~pat[0]});
      end
      cmpHigh = (c >= 3 && c < 8) ? pat[7 - c] : noise;
      @(posedge clk); #2;
    end
    chk(coarseCode == pat, "R4 published code", coarseCode, pat);
  endtask

  initial begin : watchdog
    #(200000 * 8);
    nChecks++; nErr++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end

  initial begin
    logic [4:0] prev;
    repeat (2) @(posedge clk);
    #2;
    chk(sampleEn && !frameDone && coarseCode == 5'd0 && capRailP == 4'd0 && !capMidN,
        "R2 reset state", {sampleEn, frameDone, coarseCode}, 7'b1000000);
    rstN = 1'b1;
    prev = 5'd0;
    for (int v = 0; v < 6; v++) begin
      runFrame(VEC[v][4:0], VEC[v][5], prev);
      prev = VEC[v][4:0];
    end
    chk(oscCount == 6 * 23, "R10 oscillator gated count", oscCount, 6 * 23);

    // mid-search reset: run into the coarse phase, then reset
    for (int c = 0; c < 6; c++) begin
      cmpHigh = 1'b1;
      @(posedge clk); #2;
    end
    chk(capRailP != 4'd0, "R5 partial search", capRailP, 1);
    rstN = 1'b0;
    @(posedge clk); #2;
    chk(sampleEn && !frameDone, "R2 reset restarts sampling", {sampleEn, frameDone}, 2'b10);
    chk({capRailP, capRailN, capMidP, capMidN} == 10'd0, "R2 reset clears array",
        {capRailP, capRailN, capMidP, capMidN}, 0);
    chk(coarseCode == 5'd0, "R2 reset clears code", coarseCode, 0);
    rstN = 1'b1;
    runFrame(5'b00001, 1'b1, 5'd0);
    runFrame(5'b11110, 1'b0, 5'b00001);

    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end
endmodule